// File: doc/BRIEF.md
# Dual-Rail Four-Phase Channel Link

This block moves a parallel word across a channel in which every data bit is carried on its own pair of wires: a true rail and a false rail. No request wire is used. The receiver learns that a word has arrived by checking the codewords themselves. The reverse direction has a single acknowledge wire. The sender side accepts a word with a valid strobe and drives the matching code on all pairs. It waits for acknowledge, then sends every pair back to the empty spacer and waits for acknowledge to fall before it takes the next word.

The receiver side classifies each pair as empty, zero, one or illegal. A completion detector combines these per-bit results. Acknowledge is raised, and the word captured, only when every pair carries a legal value. Acknowledge is released only when every pair has returned to spacer. A receiver stall input lets the consumer hold off acknowledge. An illegal pattern on any pair is reported as a protocol error.

The model is clocked. The rail pairs are ordinary signals. The sender outputs and the receiver inputs are separate ports, so the channel between them can be looped back or tampered with.

Top module: `dr_link`

## Requirements
- R1: Bit i of a word is carried on pair i, with the true rail at rail_t[i] and the false rail at rail_f[i]. Pattern t=0,f=0 is the spacer, t=0,f=1 is logic 0 and t=1,f=0 is logic 1. When the sender accepts a word w, the next cycle shows rail_t_o = w and rail_f_o = ~w.
- R2: While reset is held, all sender rails are 0, ack_o is 0, rx_strobe is 0 and rx_err is 0.
- R3: Once the sender drives a code, that code stays unchanged for as long as ack_i is low. In the cycle after ack_i is seen high, all sender rails are 0.
- R4: The sender keeps all rails at spacer until ack_i is low again. tx_ready is high only when the sender is idle and ack_i is low.
- R5: When every input pair holds a legal value and rx_stall is low, ack_o rises one cycle later. In that same cycle rx_word shows the true rails and rx_strobe pulses for one cycle. Every accepted word is delivered exactly once and in order.
- R6: If any input pair is at spacer while others are valid, ack_o stays low and no word is delivered.
- R7: Once ack_o is high, it stays high while any input pair is not at spacer. It falls one cycle after all pairs read 00.
- R8: If any input pair reads t=1,f=1, rx_err is high in the next cycle and acknowledge is not raised.
- R9: While rx_stall is high, ack_o does not rise, even when all pairs are valid.
- R10: The sender never drives t=1,f=1 on any pair. It never changes from one code to a different code without first passing through all-spacer.
- R11: tx_valid is ignored while tx_ready is low. Such a word is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Word offered to the sender |
| tx_word | input | W | Word to send |
| tx_ready | output | 1 | Sender can take a word this cycle |
| rail_t_o | output | W | Sender true rails |
| rail_f_o | output | W | Sender false rails |
| ack_i | input | 1 | Acknowledge seen by the sender |
| rail_t_i | input | W | Receiver true rails |
| rail_f_i | input | W | Receiver false rails |
| rx_stall | input | 1 | Consumer holds off acknowledge |
| ack_o | output | 1 | Acknowledge driven by the receiver |
| rx_word | output | W | Captured word |
| rx_strobe | output | 1 | One-cycle pulse when rx_word is updated |
| rx_err | output | 1 | Illegal pair seen in the previous cycle |

## Verification
Random words with random sender gaps and random receiver stalls run through a loopback channel. This shows that data integrity and ordering hold no matter which side is slower. Injected channel patterns test the completion logic directly. A partly filled word must not be acknowledged, which separates an all-pairs detector from an any-pair one. A single pair that is still non-empty must keep acknowledge high. An illegal pair must raise the error flag without acknowledging. A held stall with the sender mid-handshake shows that the code stays stable and that a strobe arriving while the sender is busy is dropped.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // Pair value written as {true rail, false rail}.
  typedef enum logic [1:0] {
    PAIR_EMPTY = 2'b00,
    PAIR_ZERO  = 2'b01,
    PAIR_ONE   = 2'b10,
    PAIR_BAD   = 2'b11
  } pair_e;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_CODE  = 2'd1,
    TX_SPACE = 2'd2
  } tx_state_e;

  function automatic pair_e pair_class(input logic t, input logic f);
    return pair_e'({t, f});
  endfunction
endpackage

// File: rtl/dr_rst_sync.sv
module dr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/dr_tx.sv
module dr_tx
  import dr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [W-1:0] word,
  input  logic         ack,
  output logic         ready,
  output logic [W-1:0] rail_t,
  output logic [W-1:0] rail_f
);
  tx_state_e    state_q, state_d;
  logic         load_code, load_space;
  logic [W-1:0] code_t, code_f;
  logic [W-1:0] t_q, f_q;

  for (genvar i = 0; i < W; i++) begin : g_enc
    assign code_t[i] = word[i];
    assign code_f[i] = ~word[i];
  end

  always_comb begin
    state_d    = state_q;
    load_code  = 1'b0;
    load_space = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (valid && !ack) begin
          state_d   = TX_CODE;
          load_code = 1'b1;
        end
      end
      TX_CODE: begin
        if (ack) begin
          state_d    = TX_SPACE;
          load_space = 1'b1;
        end
      end
      TX_SPACE: begin
        if (!ack) state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      t_q     <= '0;
      f_q     <= '0;
    end else begin
      state_q <= state_d;
      if (load_code) begin
        t_q <= code_t;
        f_q <= code_f;
      end else if (load_space) begin
        t_q <= '0;
        f_q <= '0;
      end
    end
  end

  assign ready  = (state_q == TX_IDLE) && !ack;
  assign rail_t = t_q;
  assign rail_f = f_q;
endmodule

// File: rtl/dr_completion.sv
module dr_completion
  import dr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] rail_t,
  input  logic [W-1:0] rail_f,
  output logic         all_valid,
  output logic         all_empty,
  output logic         any_bad
);
  logic [W-1:0] bit_valid, bit_empty, bit_bad;

  for (genvar i = 0; i < W; i++) begin : g_pair
    pair_e cls;
    assign cls          = pair_class(rail_t[i], rail_f[i]);
    assign bit_valid[i] = (cls == PAIR_ZERO) || (cls == PAIR_ONE);
    assign bit_empty[i] = (cls == PAIR_EMPTY);
    assign bit_bad[i]   = (cls == PAIR_BAD);
  end

  assign all_valid = &bit_valid;
  assign all_empty = &bit_empty;
  assign any_bad   = |bit_bad;
endmodule

// File: rtl/dr_rx.sv
module dr_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rail_t,
  input  logic [W-1:0] rail_f,
  input  logic         stall,
  output logic         ack,
  output logic [W-1:0] word,
  output logic         strobe,
  output logic         err
);
  logic         all_valid, all_empty, any_bad;
  logic         ack_q, ack_d, capture;
  logic         strobe_q, err_q;
  logic [W-1:0] word_q;

  dr_completion #(.W(W)) cdet_i (
    .rail_t    (rail_t),
    .rail_f    (rail_f),
    .all_valid (all_valid),
    .all_empty (all_empty),
    .any_bad   (any_bad)
  );

  always_comb begin
    ack_d   = ack_q;
    capture = 1'b0;
    if (!ack_q) begin
      if (all_valid && !stall) begin
        ack_d   = 1'b1;
        capture = 1'b1;
      end
    end else if (all_empty) begin
      ack_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      strobe_q <= 1'b0;
      err_q    <= 1'b0;
      word_q   <= '0;
    end else begin
      ack_q    <= ack_d;
      strobe_q <= capture;
      err_q    <= any_bad;
      if (capture) word_q <= rail_t;
    end
  end

  assign ack    = ack_q;
  assign word   = word_q;
  assign strobe = strobe_q;
  assign err    = err_q;
endmodule

// File: rtl/dr_link.sv
module dr_link #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_word,
  output logic         tx_ready,
  output logic [W-1:0] rail_t_o,
  output logic [W-1:0] rail_f_o,
  input  logic         ack_i,
  input  logic [W-1:0] rail_t_i,
  input  logic [W-1:0] rail_f_i,
  input  logic         rx_stall,
  output logic         ack_o,
  output logic [W-1:0] rx_word,
  output logic         rx_strobe,
  output logic         rx_err
);
  logic rst_n_s;

  dr_rst_sync #(.STAGES(2)) rst_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  dr_tx #(.W(W)) tx_i (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .valid  (tx_valid),
    .word   (tx_word),
    .ack    (ack_i),
    .ready  (tx_ready),
    .rail_t (rail_t_o),
    .rail_f (rail_f_o)
  );

  dr_rx #(.W(W)) rx_i (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rail_t (rail_t_i),
    .rail_f (rail_f_i),
    .stall  (rx_stall),
    .ack    (ack_o),
    .word   (rx_word),
    .strobe (rx_strobe),
    .err    (rx_err)
  );
endmodule

// File: rtl/dr_link_chk.sv
module dr_link_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_ready,
  input logic [W-1:0] rail_t_o,
  input logic [W-1:0] rail_f_o,
  input logic         ack_i,
  input logic [W-1:0] rail_t_i,
  input logic [W-1:0] rail_f_i,
  input logic         rx_stall,
  input logic         ack_o,
  input logic         rx_strobe,
  input logic         rx_err
);
  logic tx_busy_code, in_all_valid, in_all_empty, in_bad;
  assign tx_busy_code = |(rail_t_o | rail_f_o);
  assign in_all_valid = &(rail_t_i ^ rail_f_i);
  assign in_all_empty = ((rail_t_i | rail_f_i) == '0);
  assign in_bad       = |(rail_t_i & rail_f_i);

  assert_tx_no_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_t_o & rail_f_o) == '0);

  assert_tx_no_direct_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy_code |=> (($stable(rail_t_o) && $stable(rail_f_o)) ||
                      ((rail_t_o | rail_f_o) == '0)));

  assert_tx_hold_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy_code && !ack_i) |=> ($stable(rail_t_o) && $stable(rail_f_o)));

  assert_tx_spacer_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy_code && ack_i) |=> ((rail_t_o | rail_f_o) == '0));

  assert_tx_ready_needs_low_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!ack_i && !tx_busy_code));

  assert_ack_rise_on_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> ($past(in_all_valid) && !$past(rx_stall)));

  assert_strobe_with_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> $rose(ack_o));

  assert_ack_hold_until_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !in_all_empty) |=> ack_o);

  assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_bad |=> rx_err);

  assert_stall_blocks_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stall && !ack_o) |=> !ack_o);
endmodule

bind dr_link dr_link_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_ready  (tx_ready),
  .rail_t_o  (rail_t_o),
  .rail_f_o  (rail_f_o),
  .ack_i     (ack_i),
  .rail_t_i  (rail_t_i),
  .rail_f_i  (rail_f_i),
  .rx_stall  (rx_stall),
  .ack_o     (ack_o),
  .rx_strobe (rx_strobe),
  .rx_err    (rx_err)
);

// File: tb/dr_link_tb_top.sv
`timescale 1ns/1ps
module dr_link_tb_top;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         tx_valid;
  logic [W-1:0] tx_word;
  logic         tx_ready;
  logic [W-1:0] rail_t_o, rail_f_o;
  logic [W-1:0] rail_t_i, rail_f_i;
  logic         ack_i, ack_o;
  logic         rx_stall;
  logic [W-1:0] rx_word;
  logic         rx_strobe, rx_err;

  logic         inj;
  logic [W-1:0] inj_t, inj_f;

  int checks, failures;
  int sent_cnt, rcv_cnt;
  bit saw_illegal;
  bit drv_done;
  logic [W-1:0] exp_q[$];

  assign rail_t_i = inj ? inj_t : rail_t_o;
  assign rail_f_i = inj ? inj_f : rail_f_o;
  assign ack_i    = ack_o;

  dr_link #(.W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_word   (tx_word),
    .tx_ready  (tx_ready),
    .rail_t_o  (rail_t_o),
    .rail_f_o  (rail_f_o),
    .ack_i     (ack_i),
    .rail_t_i  (rail_t_i),
    .rail_f_i  (rail_f_i),
    .rx_stall  (rx_stall),
    .ack_o     (ack_o),
    .rx_word   (rx_word),
    .rx_strobe (rx_strobe),
    .rx_err    (rx_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops the expected word on every delivery.
  always @(negedge clk) begin
    if (rst_n && !inj && rx_strobe) begin
      rcv_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected word", {24'd0, rx_word}, 32'd0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(rx_word == e, "R5 word order/integrity", {24'd0, rx_word}, {24'd0, e});
      end
    end
    if (rst_n && ((rail_t_o & rail_f_o) != '0)) saw_illegal = 1'b1;
  end

  task automatic send(input logic [W-1:0] w, input int gap);
    for (int k = 0; k < gap; k++) @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_word  = w;
    exp_q.push_back(w);
    sent_cnt++;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_word  = ~w;
    chk(rail_t_o == w && rail_f_o == ~w, "R1 rail encoding",
        {16'd0, rail_t_o, rail_f_o}, {16'd0, w, ~w});
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #200000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; sent_cnt = 0; rcv_cnt = 0;
    saw_illegal = 1'b0; drv_done = 1'b0;
    rst_n = 1'b0; tx_valid = 1'b0; tx_word = '0; rx_stall = 1'b0;
    inj = 1'b0; inj_t = '0; inj_f = '0;
    cyc(3);
    chk(rail_t_o == '0 && rail_f_o == '0 && !ack_o && !rx_strobe && !rx_err,
        "R2 reset state", {16'd0, rail_t_o, rail_f_o},
        32'd0);
    rst_n = 1'b1;
    cyc(4);
    chk(tx_ready == 1'b1, "R4 ready when idle", {31'd0, tx_ready}, 32'd1);

    // Stalled receiver: the code must hold and a busy-time strobe is dropped.
    rx_stall = 1'b1;
    send(8'hA5, 0);
    cyc(3);
    chk(rail_t_o == 8'hA5 && rail_f_o == 8'h5A, "R3 code held while ack low",
        {16'd0, rail_t_o, rail_f_o}, {16'd0, 8'hA5, 8'h5A});
    chk(!ack_o, "R9 stall keeps ack low", {31'd0, ack_o}, 32'd0);
    chk(!tx_ready, "R4 not ready mid handshake", {31'd0, tx_ready}, 32'd0);
    tx_valid = 1'b1; tx_word = 8'h3C;
    cyc(1);
    tx_valid = 1'b0;
    chk(rail_t_o == 8'hA5, "R11 busy strobe ignored", {24'd0, rail_t_o}, {24'd0, 8'hA5});
    rx_stall = 1'b0;
    cyc(1);
    chk(ack_o && rx_strobe, "R5 ack one cycle after complete", {30'd0, ack_o, rx_strobe}, 32'd3);
    cyc(1);
    chk(rail_t_o == '0 && rail_f_o == '0, "R3 spacer after ack",
        {16'd0, rail_t_o, rail_f_o}, 32'd0);
    chk(ack_o && !rx_strobe, "R5 single strobe", {30'd0, ack_o, rx_strobe}, 32'd2);
    cyc(1);
    chk(!ack_o && !tx_ready && rail_t_o == '0, "R4 spacer until ack low",
        {30'd0, ack_o, tx_ready}, 32'd0);
    cyc(1);
    chk(tx_ready, "R4 ready after ack low", {31'd0, tx_ready}, 32'd1);
    cyc(4);

    // Random traffic with random gaps and receiver stalls.
    fork
      begin
        for (int n = 0; n < 60; n++) send(W'($urandom), int'($urandom_range(0, 3)));
        drv_done = 1'b1;
      end
      begin
        while (!drv_done) begin
          @(negedge clk);
          rx_stall = ($urandom_range(0, 2) == 0);
        end
        rx_stall = 1'b0;
      end
    join
    cyc(20);
    chk(exp_q.size() == 0 && rcv_cnt == sent_cnt, "R5 R11 all words once",
        rcv_cnt, sent_cnt);
    chk(!saw_illegal, "R10 sender never drove 11", {31'd0, saw_illegal}, 32'd0);

    // Injected channel patterns against the receiver.
    inj = 1'b1;
    inj_t = 8'h0F; inj_f = 8'h00;
    cyc(2);
    chk(!ack_o && !rx_strobe, "R6 partial word not acked", {30'd0, ack_o, rx_strobe}, 32'd0);
    inj_f = 8'hF0;
    cyc(1);
    chk(ack_o && rx_strobe && rx_word == 8'h0F, "R5 R1 injected capture",
        {23'd0, ack_o, rx_word}, {23'd1, 8'h0F});
    inj_t = 8'h0E;
    cyc(2);
    chk(ack_o, "R7 ack held while one pair busy", {31'd0, ack_o}, 32'd1);
    inj_t = 8'h00; inj_f = 8'h00;
    cyc(1);
    chk(!ack_o, "R7 ack falls after all spacer", {31'd0, ack_o}, 32'd0);
    cyc(2);
    inj_t = 8'hFF; inj_f = 8'h01;
    cyc(1);
    chk(rx_err && !ack_o, "R8 illegal pair flagged", {30'd0, rx_err, ack_o}, 32'd2);
    inj_t = 8'h00; inj_f = 8'h00;
    cyc(1);
    chk(!rx_err, "R8 error clears", {31'd0, rx_err}, 32'd0);
    rx_stall = 1'b1;
    inj_t = 8'h81; inj_f = 8'h7E;
    cyc(3);
    chk(!ack_o && !rx_strobe, "R9 stall with full word", {30'd0, ack_o, rx_strobe}, 32'd0);
    rx_stall = 1'b0;
    cyc(1);
    chk(ack_o && rx_word == 8'h81, "R9 ack after stall release",
        {23'd0, ack_o, rx_word}, {23'd1, 8'h81});
    inj_t = 8'h00; inj_f = 8'h00;
    cyc(3);
    inj = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule